// File: doc/BRIEF.md
# Input Sample Format Converter

This block sits at the front of a receive channel. It takes one 16-bit parallel word per enabled clock, interprets it in one of several number formats picked by a configuration input, and hands a signed linear sample to the mixer that follows. The supported formats are plain two's complement, offset binary, and a compact floating-point form. The floating-point form carries a 14-bit mantissa and a 2-bit exponent, and each exponent step is worth 6 dB.

Next to the linear sample the block produces a rectified copy for an input level detector. When rectification is on, a negative sample is ones'-complemented, which gives a cheap magnitude with no carry chain. The format and rectify controls are taken in the same cycle as the data word, so they may change between words.

The data path is one register deep. The source offers a word by pulling its active-low enable low. The block has no back-pressure: every enabled word is taken. The sink must accept every cycle in which `smp_valid` is high, because the result is replaced on the next enabled word.

Top module: `insfc_top`

## Requirements
- R1: A word on `src_word` is taken at a rising `clk` edge only while `src_en_n` is low. `smp_valid` is high in the cycle that follows such an edge, and the result appears on `smp_lin` and `smp_mag` in that same cycle.
- R2: After a rising edge at which `src_en_n` is high, `smp_valid` is low and `smp_lin` and `smp_mag` keep their previous values, whatever the other inputs do.
- R3: With `cfg_fmt` = 2'b00 (two's complement), `smp_lin` is `src_word` sign-extended to 18 bits.
- R4: With `cfg_fmt` = 2'b01 (offset binary), bit 15 of the word is inverted and the result is sign-extended. 16'h0000 gives -32768, 16'h8000 gives 0, and 16'hFFFF gives 32767.
- R5: With `cfg_fmt` = 2'b10 (floating point), bits 15:2 are a signed two's-complement mantissa and bits 1:0 an exponent code. For codes 0, 1 and 2, `smp_lin` is the mantissa shifted left by the code (+6 dB per step), so shifted-out low bits are zero.
- R6: In floating-point mode, exponent code 2'b11 saturates and gives the same result as code 2'b10.
- R7: `cfg_fmt` = 2'b11 is reserved and behaves as two's complement.
- R8: With `cfg_rect` high at the taking edge, a negative linear sample gives `smp_mag` = bitwise NOT of `smp_lin`, and a non-negative one gives `smp_mag` = `smp_lin`. The sign bit of `smp_mag` is therefore always clear.
- R9: With `cfg_rect` low at the taking edge, `smp_mag` equals `smp_lin`.
- R10: A synchronous reset (`rst` high at a rising edge) clears `smp_valid`, `smp_lin` and `smp_mag` to zero, even if `src_en_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fmt | input | 2 | Input format: 00 two's complement, 01 offset binary, 10 float, 11 reserved (as 00) |
| cfg_rect | input | 1 | Rectify the level-detector output |
| src_word | input | 16 | Parallel input sample |
| src_en_n | input | 1 | Active-low enable; a word is taken while low |
| smp_valid | output | 1 | High for one cycle per word taken |
| smp_lin | output | 18 | Signed linear sample for the mixer |
| smp_mag | output | 18 | Rectified (or pass-through) sample for the level detector |

## Verification
Both end points of each fixed-point format are applied: the most positive and most negative two's-complement words, and the all-zero, mid-scale and all-ones offset-binary words. These show whether the MSB inversion and the sign extension are right. Floating-point words use the same mantissa with every exponent code, which separates a correct shift from a missing or over-long one and shows that code 11 saturates. The most negative mantissa and the all-ones mantissa check sign handling after shifting. Rectification is tried on negative and positive samples with the control both on and off. Idle cycles with changing inputs, and a reset asserted while the enable is low, show that results hold and clear as required.

// File: rtl/insfc_pkg.sv
package insfc_pkg;
  typedef enum logic [1:0] {
    FMT_TWOS   = 2'b00,
    FMT_OFFSET = 2'b01,
    FMT_FLOAT  = 2'b10,
    FMT_RSVD   = 2'b11
  } fmt_e;
endpackage

// File: rtl/insfc_decode.sv
module insfc_decode
  import insfc_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 2,
  parameter int OUT_W = IN_W + 2
) (
  input  fmt_e                    fmt,
  input  logic [IN_W-1:0]         word,
  output logic signed [OUT_W-1:0] lin
);
  localparam int MAN_W = IN_W - EXP_W;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  logic signed [OUT_W-1:0] fixed_ext;
  logic signed [OUT_W-1:0] offs_ext;
  logic signed [OUT_W-1:0] man_ext;
  logic [EXP_W-1:0]        exp_code;
  logic [EXP_W-1:0]        shift;

  always_comb begin
    fixed_ext = {{(OUT_W-IN_W){word[IN_W-1]}}, word};
    offs_ext  = {{(OUT_W-IN_W){~word[IN_W-1]}}, ~word[IN_W-1], word[IN_W-2:0]};
    man_ext   = {{(OUT_W-MAN_W){word[IN_W-1]}}, word[IN_W-1:EXP_W]};
    exp_code  = word[EXP_W-1:0];
    // top exponent code saturates at the code below it
    shift     = (exp_code == EXP_TOP) ? EXP_TOP - 1'b1 : exp_code;
    unique case (fmt)
      FMT_OFFSET: lin = offs_ext;
      FMT_FLOAT:  lin = man_ext <<< shift;
      default:    lin = fixed_ext;
    endcase
  end
endmodule

// File: rtl/insfc_rectify.sv
module insfc_rectify #(
  parameter int W = 18
) (
  input  logic         rect_en,
  input  logic [W-1:0] lin,
  output logic [W-1:0] mag
);
  always_comb begin
    if (rect_en && lin[W-1]) mag = ~lin;
    else                     mag = lin;
  end
endmodule

// File: rtl/insfc_stage.sv
module insfc_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] lin_d,
  input  logic [W-1:0] mag_d,
  output logic         valid_q,
  output logic [W-1:0] lin_q,
  output logic [W-1:0] mag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      lin_q   <= '0;
      mag_q   <= '0;
    end else begin
      valid_q <= ~en_n;
      if (!en_n) begin
        lin_q <= lin_d;
        mag_q <= mag_d;
      end
    end
  end

  AST_VALID_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (valid_q == $past(!en_n))) else $error("valid mismatch"); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !valid_q) |-> ($stable(lin_q) && $stable(mag_q))) else $error("idle change"); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!valid_q && lin_q == '0 && mag_q == '0)) else $error("reset not clear"); // R10
endmodule

// File: rtl/insfc_top.sv
module insfc_top
  import insfc_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int EXP_W = 2,
  parameter int OUT_W = IN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_rect,
  input  logic [IN_W-1:0]  src_word,
  input  logic             src_en_n,
  output logic             smp_valid,
  output logic [OUT_W-1:0] smp_lin,
  output logic [OUT_W-1:0] smp_mag
);
  logic signed [OUT_W-1:0] lin_c;
  logic [OUT_W-1:0]        mag_c;

  insfc_decode #(.IN_W(IN_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_decode (
    .fmt  (fmt_e'(cfg_fmt)),
    .word (src_word),
    .lin  (lin_c)
  );

  insfc_rectify #(.W(OUT_W)) u_rect (
    .rect_en (cfg_rect),
    .lin     (lin_c),
    .mag     (mag_c)
  );

  insfc_stage #(.W(OUT_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .en_n    (src_en_n),
    .lin_d   (lin_c),
    .mag_d   (mag_c),
    .valid_q (smp_valid),
    .lin_q   (smp_lin),
    .mag_q   (smp_mag)
  );

  AST_RECT_SIGN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && $past(cfg_rect)) |-> !smp_mag[OUT_W-1]) else $error("rect sign"); // R8

  AST_RECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !$past(cfg_rect)) |-> (smp_mag == smp_lin)) else $error("rect pass"); // R9

  AST_FLOAT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!src_en_n && cfg_fmt == FMT_FLOAT && src_word[EXP_W-1:0] != '0) |=> !smp_lin[0])
    else $error("float shift"); // R5
endmodule

// File: tb/insfc_top_bench.sv
module insfc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_fmt;
  logic        cfg_rect;
  logic [15:0] src_word;
  logic        src_en_n;
  logic        smp_valid;
  logic [17:0] smp_lin;
  logic [17:0] smp_mag;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insfc_top u_insfc_top (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_rect(cfg_rect),
    .src_word(src_word), .src_en_n(src_en_n),
    .smp_valid(smp_valid), .smp_lin(smp_lin), .smp_mag(smp_mag)
  );

  // {fmt[54:53], rect[52], word[51:36], lin[35:18], mag[17:0]}
  localparam logic [54:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h7FFF, 18'h07FFF, 18'h07FFF},
    {2'd0, 1'b0, 16'h8000, 18'h38000, 18'h38000},
    {2'd0, 1'b1, 16'hFFFF, 18'h3FFFF, 18'h00000},
    {2'd1, 1'b0, 16'h0000, 18'h38000, 18'h38000},
    {2'd1, 1'b0, 16'h8000, 18'h00000, 18'h00000},
    {2'd1, 1'b0, 16'hFFFF, 18'h07FFF, 18'h07FFF},
    {2'd2, 1'b0, 16'h0015, 18'h0000A, 18'h0000A},
    {2'd2, 1'b0, 16'h0016, 18'h00014, 18'h00014},
    {2'd2, 1'b0, 16'h0017, 18'h00014, 18'h00014},
    {2'd2, 1'b1, 16'h8003, 18'h38000, 18'h07FFF},
    {2'd2, 1'b0, 16'hFFFC, 18'h3FFFF, 18'h3FFFF},
    {2'd2, 1'b0, 16'h7FFE, 18'h07FFC, 18'h07FFC},
    {2'd3, 1'b0, 16'h8001, 18'h38001, 18'h38001},
    {2'd1, 1'b1, 16'h7FFE, 18'h3FFFE, 18'h00001},
    {2'd0, 1'b1, 16'h1234, 18'h01234, 18'h01234}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string fmt_tag(input logic [1:0] f, input logic [15:0] w);
    case (f)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return (w[1:0] == 2'b11) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [1:0] f, input logic r, input logic [15:0] w, input logic en_n);
    @(negedge clk);
    cfg_fmt = f; cfg_rect = r; src_word = w; src_en_n = en_n;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [17:0] hold_lin, hold_mag;
    rst = 1'b1; cfg_fmt = 2'd0; cfg_rect = 1'b0; src_word = 16'h5555; src_en_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", {17'd0, smp_valid}, 18'd0);
    chk("R10 reset lin", smp_lin, 18'd0);
    chk("R10 reset mag", smp_mag, 18'd0);
    @(negedge clk); rst = 1'b0; src_en_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][54:53], VEC[i][52], VEC[i][51:36], 1'b0);
      chk("R1 valid", {17'd0, smp_valid}, 18'd1);
      chk(fmt_tag(VEC[i][54:53], VEC[i][51:36]), smp_lin, VEC[i][35:18]);
      chk(VEC[i][52] ? "R8" : "R9", smp_mag, VEC[i][17:0]);
    end

    // R2: idle cycles with changing inputs hold the last result
    hold_lin = smp_lin; hold_mag = smp_mag;
    apply(2'd2, 1'b1, 16'h8002, 1'b1);
    chk("R2 valid low", {17'd0, smp_valid}, 18'd0);
    chk("R2 lin hold", smp_lin, hold_lin);
    chk("R2 mag hold", smp_mag, hold_mag);
    apply(2'd1, 1'b0, 16'h0000, 1'b1);
    chk("R2 lin hold 2", smp_lin, hold_lin);

    // R9: negative sample with rectify off passes through
    apply(2'd0, 1'b0, 16'hFFF0, 1'b0);
    chk("R9 lin", smp_lin, 18'h3FFF0);
    chk("R9 mag", smp_mag, 18'h3FFF0);

    // R10: reset while enable is low clears outputs
    @(negedge clk); rst = 1'b1; src_en_n = 1'b0; src_word = 16'h7000;
    @(posedge clk); #1;
    chk("R10 mid reset valid", {17'd0, smp_valid}, 18'd0);
    chk("R10 mid reset lin", smp_lin, 18'd0);
    @(negedge clk); rst = 1'b0; src_en_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 no word no valid", {17'd0, smp_valid}, 18'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule